// File: doc/BRIEF.md
# Alternating-Bank Serial Delay Line

This block is a serial-in, serial-out delay line of even length N whose storage is split into two banks of N/2 flip-flops. One bank captures the incoming bit on even cycles and the other on odd cycles. A one-flip-flop phase register, toggling on every clock, decides which bank shifts and also steers a two-way output multiplexer. At the ports the block behaves like a plain N-flop shift chain clocked every cycle, with the same data rate and latency. Inside, only half of the storage can change on any edge, so the average number of toggling flip-flops is roughly halved.

An N-bit parallel load replaces the whole line in one cycle. The load vector is spread over the two banks using the current phase, so the bits then leave in the same order a conventional chain would produce. A typical use is a long, low-activity delay or scrambler state store where clock-edge switching power matters more than a few extra multiplexers.

Top module: `dual_bank_shreg`

## Requirements
- R1: While `rst_n` is low, `dout` is 0, and both banks and the phase are cleared. With `din` held at 0 after release, `dout` stays 0.
- R2: Without loads, the bit on `din` at a rising edge appears on `dout` from just after the (N-1)-th following rising edge until the N-th. This is exactly the output of an N-flop chain whose last flop drives `dout`.
- R3: The phase bit is 0 after reset and inverts on every rising edge. The even bank shifts on edges where the phase is 0, and the odd bank shifts on edges where it is 1.
- R4: On any edge without a load, the bank that is not selected by the phase keeps all its bits.
- R5: The active bank takes the current `din` into its first stage on its shifting edge.
- R6: A load of vector V (bit index 0 is the stage nearest `din`, bit N-1 the stage driving `dout`) makes `dout` show V[N-1], V[N-2], …, V[0] on the following N cycles. After that come the bits shifted in later. This holds whatever the phase was at the load edge.
- R7: `din` is ignored on a load edge: that bit never reaches `dout`.
- R8: On back-to-back loads, the later vector fully replaces the earlier one.
- R9: Without a load, at most N/2 storage flip-flops change on any edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | 1 | Serial data in |
| load | input | 1 | Parallel load strobe, takes priority over shifting |
| load_vec | input | N | Parallel image; bit N-1 is output first |
| dout | output | 1 | Serial data out |

## Verification
A wrong phase or a bank that shifts on the wrong edge interleaves the two half-streams wrongly. This shows as swapped adjacent bits on `dout` within N cycles of the fault. A load image spread over the banks with the wrong phase rule swaps bit pairs of V, and this is visible on the first or second cycle after the load. Toggle economy cannot be seen at the ports, so it is guarded by a property on the bank contents while the bench streams dense data through the line.

// File: rtl/dbsr_pkg.sv
package dbsr_pkg;

  typedef enum logic {PH_EVEN = 1'b0, PH_ODD = 1'b1} phase_e;

  // Bank that holds the oldest bit for the current phase.
  function automatic logic out_pick(input logic phase, input logic even_tail, input logic odd_tail);
    return (phase == PH_ODD) ? odd_tail : even_tail;
  endfunction

  // Load rule: with phase 0 at the load edge the even bank takes the even stages.
  function automatic logic load_pick(input logic phase, input logic stage_even, input logic stage_odd);
    return (phase == PH_EVEN) ? stage_even : stage_odd;
  endfunction

endpackage

// File: rtl/dbsr_phase.sv
module dbsr_phase (
  input  logic clk,
  input  logic rst_n,
  output logic phase_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= 1'b0;
    else        phase_q <= ~phase_q;
  end

  AST_PHASE_ALTERNATES: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (phase_q != $past(phase_q))); // R3

endmodule

// File: rtl/dbsr_bank.sv
module dbsr_bank #(
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             load,
  input  logic             din,
  input  logic [DEPTH-1:0] pv,
  output logic [DEPTH-1:0] q
);

  logic [DEPTH-1:0] shifted;

  generate
    if (DEPTH == 1) begin : g_single
      assign shifted = din;
    end else begin : g_chain
      assign shifted = {q[DEPTH-2:0], din};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= pv;
    else if (en)   q <= shifted;
  end

  AST_IDLE_BANK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !load) |=> $stable(q)); // R4

endmodule

// File: rtl/dual_bank_shreg.sv
module dual_bank_shreg
  import dbsr_pkg::*;
#(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         din,
  input  logic         load,
  input  logic [N-1:0] load_vec,
  output logic         dout
);

  localparam int HALF = N / 2;

  logic            phase_q;
  logic            even_en;
  logic            odd_en;
  logic [HALF-1:0] even_q;
  logic [HALF-1:0] odd_q;
  logic [HALF-1:0] even_pv;
  logic [HALF-1:0] odd_pv;
  logic            even_tail;
  logic            odd_tail;

  dbsr_phase u_phase (
    .clk     (clk),
    .rst_n   (rst_n),
    .phase_q (phase_q)
  );

  assign even_en = (phase_q == PH_EVEN);
  assign odd_en  = (phase_q == PH_ODD);

  for (genvar j = 0; j < HALF; j++) begin : g_map
    assign even_pv[j] = load_pick(phase_q, load_vec[2*j],   load_vec[2*j+1]);
    assign odd_pv[j]  = load_pick(phase_q, load_vec[2*j+1], load_vec[2*j]);
  end

  dbsr_bank #(.DEPTH(HALF)) u_even (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (even_en),
    .load  (load),
    .din   (din),
    .pv    (even_pv),
    .q     (even_q)
  );

  dbsr_bank #(.DEPTH(HALF)) u_odd (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (odd_en),
    .load  (load),
    .din   (din),
    .pv    (odd_pv),
    .q     (odd_q)
  );

  assign even_tail = even_q[HALF-1];
  assign odd_tail  = odd_q[HALF-1];
  assign dout      = out_pick(phase_q, even_tail, odd_tail);

  AST_ENTRY_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && even_en) |=> (even_q[0] == $past(din))); // R5

  AST_LOAD_HEAD_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (dout == $past(load_vec[N-1]))); // R6

  AST_HALF_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($countones({even_q, odd_q} ^ $past({even_q, odd_q})) <= HALF)); // R9

endmodule

// File: tb/tb_dual_bank_shreg.sv
module tb_dual_bank_shreg;

  localparam int N = 8;
  localparam int MAXCYC = 200000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         din = 1'b0;
  logic         load = 1'b0;
  logic [N-1:0] load_vec = '0;
  logic         dout;

  logic [N-1:0] model_q;
  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dual_bank_shreg #(.N(N)) dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .din      (din),
    .load     (load),
    .load_vec (load_vec),
    .dout     (dout)
  );

  // Plain N-flop chain used as the expected output.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n)    model_q <= '0;
    else if (load) model_q <= load_vec;
    else           model_q <= {model_q[N-2:0], din};
  end

  always @(posedge clk) cycles <= cycles + 1;

  task automatic check(input logic got, input logic exp, input string req);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: dout=%0b expected=%0b at cycle %0d", req, got, exp, cycles);
    end
  endtask

  task automatic step(input string req);
    @(negedge clk);
    check(dout, model_q[N-1], req);
  endtask

  initial begin
    // Reset state
    #1;
    check(dout, 1'b0, "R1");
    repeat (3) @(negedge clk);
    check(dout, 1'b0, "R1");
    rst_n = 1'b1;
    for (int i = 0; i < N + 2; i++) step("R1");

    // Single marker: latency of exactly N
    din = 1'b1;
    step("R2");
    din = 1'b0;
    for (int i = 0; i < N + 2; i++) step("R2");

    // Every N-bit word streamed serially, dense toggling data (R3, R5, R9 stimulus)
    for (int w = 0; w < (1 << N); w++) begin
      for (int b = 0; b < N; b++) begin
        din = w[b];
        step("R2_R3_R5_R9");
      end
    end

    // Loads at both phases, din set to the opposite of the dropped stage
    for (int v = 0; v < (1 << N); v++) begin
      for (int par = 0; par < 2; par++) begin
        din = v[0];
        for (int k = 0; k < par; k++) step("R4");
        load = 1'b1;
        load_vec = v[N-1:0];
        din = ~v[N-1];
        step("R6_R7");
        load = 1'b0;
        for (int k = 0; k < N; k++) begin
          din = 1'b0;
          step("R6");
        end
      end
    end

    // Back-to-back loads
    for (int par = 0; par < 2; par++) begin
      for (int k = 0; k < par; k++) step("R8");
      load = 1'b1;
      load_vec = 8'hFF;
      step("R8");
      load_vec = 8'h5A;
      din = 1'b1;
      step("R8");
      load = 1'b0;
      din = 1'b0;
      for (int k = 0; k < N + 1; k++) step("R8");
    end

    // Reset in mid-stream clears everything
    load = 1'b1;
    load_vec = '1;
    step("R1");
    load = 1'b0;
    din = 1'b1;
    step("R1");
    rst_n = 1'b0;
    #1;
    check(dout, 1'b0, "R1");
    din = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < N + 2; i++) begin
      step("R1");
      check(dout, 1'b0, "R1");
    end

    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(8 * MAXCYC);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: run=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule